// File: doc/BRIEF.md
# External interrupt sensitivity controller

This block watches four external interrupt pins and turns the activity on them into interrupt requests for a processor. Each line has a 2-bit sensitivity setting, and the four settings share one byte-wide control register. The setting selects one of four modes: rising edge, falling edge, both edges, or falling edge combined with a request that lasts while the pin stays low. Pins pass through a two-stage synchroniser before any edge or level is examined.

A line takes part only when its port pin is set up as an input with the interrupt option switched on. Every other direction and option combination keeps the line silent. Requests that are pending at the same time are ordered by a fixed priority, with line 0 highest. The block drives one request output and the index of the winning line. An acknowledge given while a request is shown retires the pending edge of that line.

An edge request stays pending until it is acknowledged. A level request follows the synchronised pin on every cycle. Rewriting a line's sensitivity field to a different value drops any edge request already pending on that line.

Top module: `eirq_ctrl`

## Requirements
- R1: The control byte is written through `cfg_we_i`/`cfg_wdata_i`. Line i uses bits [2i+1:2i], so line 3 sits in bits 7:6 and line 0 in bits 1:0. The byte resets to 00h, and right after reset with all pins high no request is shown.
- R2: Field value 01 raises a request on a rising edge of the pin only. A falling edge or a steady low level raises nothing.
- R3: Field value 00 raises a request on a falling edge and keeps requesting for as long as the synchronised pin is low, even after an acknowledge. The request ends once the pin is high again.
- R4: Field value 10 raises a request on a falling edge only. After an acknowledge, a pin that stays low raises nothing more.
- R5: Field value 11 raises a request on both rising and falling edges.
- R6: A line is enabled only when its direction bit `pin_dir_i[i]` is 0 and its option bit `pin_opt_i[i]` is 1. With direction 1, or with direction 0 and option 0, the line never requests.
- R7: When several lines request at once, `irq_id_o` gives the binary index of the lowest-numbered requesting line, and `irq_req_o` is high whenever any line requests.
- R8: An edge request stays pending until `irq_ack_i` is high in a cycle where `irq_req_o` is high and `irq_id_o` names that line. An acknowledge given with no request showing has no effect.
- R9: A write that changes a line's field clears that line's pending edge request. Other lines, and writes that leave the field unchanged, keep their pending requests.
- R10: A pin change seen at the inputs before clock edge k shows as a level request after edge k+1. It shows as an edge request after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the sensitivity byte |
| cfg_wdata_i | input | 8 | New sensitivity byte, 2 bits per line |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| pin_dir_i | input | 4 | Port direction bits (0 = input) |
| pin_opt_i | input | 4 | Port option bits (1 = interrupt enabled) |
| irq_ack_i | input | 1 | Acknowledge of the line shown on `irq_id_o` |
| irq_req_o | output | 1 | Any enabled line requests |
| irq_id_o | output | 2 | Index of the winning line |

## Verification
The assertions check on every cycle that:
- the winner shown is the lowest-numbered pending line;
- a disabled line holds no edge request;
- a pending edge survives until it is acknowledged, disabled or reconfigured;
- a changed field clears the request;
- a rising-only line picks up nothing without a synchronised rising edge.

Only the bench's scenarios can show the rest:
- the behaviour of each encoding against real pin waveforms;
- the exact synchroniser latency;
- the level request outliving an acknowledge;
- the order in which simultaneous requests are served one acknowledge after another.

// File: rtl/eirq_pkg.sv
// Shared definitions for the external interrupt sensitivity controller.
// Assumes every line uses the same 2-bit sensitivity encoding.
package eirq_pkg;
    localparam int SENSE_W = 2;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_FALL_LOW = 2'b00,   // falling edge plus low level
        SENSE_RISE     = 2'b01,   // rising edge only
        SENSE_FALL     = 2'b10,   // falling edge only
        SENSE_BOTH     = 2'b11    // rising and falling edges
    } sense_e;
endpackage

// File: rtl/eirq_sync.sv
// Multi-stage synchroniser for a bus of asynchronous pins.
// Every stage resets to 1 (idle-high pins), so no edge appears at reset release.
// Assumes STAGES >= 2.
module eirq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= async_i;
            end
        end else begin : g_next
            // Later stages shift the sampled value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/eirq_line.sv
// Edge and level detection for one interrupt line.
// Works on the synchronised pin. It holds a sticky edge-pending flag and adds
// a live low-level request in falling-plus-low mode.
// Assumes the previous-sample register resets to 1, the same as the synchroniser.
module eirq_line
    import eirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_s,     // synchronised pin
    input  logic [SENSE_W-1:0] mode_i,    // sensitivity field of this line
    input  logic               line_en,   // direction = input and option = on
    input  logic               cfg_chg,   // field rewritten to a new value
    input  logic               ack_hit,   // acknowledge addressed to this line
    output logic               req_o
);
    sense_e mode_e;
    logic   prev_q;
    logic   edge_pend;
    logic   rise, fall, hit, level_act;

    assign mode_e = sense_e'(mode_i);
    assign rise   = pin_s & ~prev_q;
    assign fall   = ~pin_s & prev_q;

    // Select which detected transitions count under the current mode.
    always_comb begin
        unique case (mode_e)
            SENSE_RISE:     hit = rise;
            SENSE_FALL:     hit = fall;
            SENSE_BOTH:     hit = rise | fall;
            default:        hit = fall;
        endcase
        hit = hit & line_en;
    end

    assign level_act = line_en && (mode_e == SENSE_FALL_LOW) && !pin_s;

    // Remember the last synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_s;
    end

    // Sticky edge flag: a reconfiguration or disable clears it first,
    // then a new edge sets it, then an acknowledge clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                   edge_pend <= 1'b0;
        else if (cfg_chg || !line_en) edge_pend <= 1'b0;
        else if (hit)                 edge_pend <= 1'b1;
        else if (ack_hit)             edge_pend <= 1'b0;
    end

    assign req_o = edge_pend | level_act;

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) // R6
        !line_en |=> !edge_pend);
    AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n) // R8
        (edge_pend && !ack_hit && !cfg_chg && line_en) |=> edge_pend);
    AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) // R9
        cfg_chg |=> !edge_pend);
    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) // R2
        (mode_e == SENSE_RISE && !edge_pend && !$rose(pin_s)) |=> !edge_pend);
endmodule

// File: rtl/eirq_arbiter.sv
// Fixed-priority selector: the lowest-numbered pending line wins.
// Purely combinational. Assumes ID_W can index every line.
module eirq_arbiter #(
    parameter int N    = 4,
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    pend_i,
    output logic            req_o,
    output logic [ID_W-1:0] id_o
);
    // Scan from the lowest priority upwards so the lowest index is kept last.
    always_comb begin
        id_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) id_o = ID_W'(i);
        end
    end

    assign req_o = |pend_i;

    AST_PRIO_WIN: assert property (@(posedge clk) disable iff (!rst_n) // R7
        req_o |-> (pend_i[id_o] && ((pend_i & ((N'(1) << id_o) - N'(1))) == '0)));
endmodule

// File: rtl/eirq_ctrl.sv
// External interrupt sensitivity controller, top level.
// Holds the sensitivity byte, synchronises the pins, runs one detector per
// line and arbitrates the requests by fixed priority.
// Assumes NUM_LINES >= 2. An acknowledge retires the line shown on irq_id_o.
module eirq_ctrl
    import eirq_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CFG_W      = SENSE_W * NUM_LINES,
    localparam int ID_W       = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we_i,
    input  logic [CFG_W-1:0]     cfg_wdata_i,
    input  logic [NUM_LINES-1:0] pin_i,
    input  logic [NUM_LINES-1:0] pin_dir_i,
    input  logic [NUM_LINES-1:0] pin_opt_i,
    input  logic                 irq_ack_i,
    output logic                 irq_req_o,
    output logic [ID_W-1:0]      irq_id_o
);
    logic [CFG_W-1:0]     cfg_q;
    logic [NUM_LINES-1:0] pin_s;
    logic [NUM_LINES-1:0] line_req;

    // Sensitivity byte; resets to all lines in falling-plus-low mode.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= '0;
        else if (cfg_we_i) cfg_q <= cfg_wdata_i;
    end

    eirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_s)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic chg, en, ack;
        assign chg = cfg_we_i &&
                     (cfg_wdata_i[SENSE_W*i +: SENSE_W] != cfg_q[SENSE_W*i +: SENSE_W]);
        assign en  = !pin_dir_i[i] && pin_opt_i[i];
        assign ack = irq_ack_i && irq_req_o && (irq_id_o == ID_W'(i));

        eirq_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_s   (pin_s[i]),
            .mode_i  (cfg_q[SENSE_W*i +: SENSE_W]),
            .line_en (en),
            .cfg_chg (chg),
            .ack_hit (ack),
            .req_o   (line_req[i])
        );
    end

    eirq_arbiter #(.N(NUM_LINES), .ID_W(ID_W)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (line_req),
        .req_o  (irq_req_o),
        .id_o   (irq_id_o)
    );
endmodule

// File: tb/tb_eirq_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_eirq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [7:0] cfg_wdata_i = '0;
    logic [3:0] pin_i = '1;
    logic [3:0] pin_dir_i = '0;
    logic [3:0] pin_opt_i = '1;
    logic       irq_ack_i = 1'b0;
    logic       irq_req_o;
    logic [1:0] irq_id_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eirq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .pin_i(pin_i), .pin_dir_i(pin_dir_i), .pin_opt_i(pin_opt_i),
        .irq_ack_i(irq_ack_i), .irq_req_o(irq_req_o), .irq_id_o(irq_id_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        pin_i = '1; pin_dir_i = '0; pin_opt_i = '1;
        irq_ack_i = 1'b0; cfg_we_i = 1'b0;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(2);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_we_i = 1'b1; cfg_wdata_i = v;
        step(1);
        cfg_we_i = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack_i = 1'b1;
        step(1);
        irq_ack_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset req", irq_req_o, 0);
        step(5);
        chk("R1 idle req stays low", irq_req_o, 0);
    endtask

    task automatic t_level();
        do_reset();
        pin_i[1] = 1'b0;
        step(2);
        chk("R3/R10 level req after 2 edges", irq_req_o, 1);
        chk("R3 level id", irq_id_o, 1);
        step(1);
        ack_pulse();
        chk("R3 level holds after ack", irq_req_o, 1);
        pin_i[1] = 1'b1;
        step(3);
        chk("R3 level gone when high", irq_req_o, 0);
    endtask

    task automatic t_rise();
        do_reset();
        write_cfg(8'h10);
        pin_i[2] = 1'b0;
        step(4);
        chk("R2 no req on falling", irq_req_o, 0);
        pin_i[2] = 1'b1;
        step(2);
        chk("R10 edge not yet visible", irq_req_o, 0);
        step(1);
        chk("R2 req on rising", irq_req_o, 1);
        chk("R2 id", irq_id_o, 2);
        ack_pulse();
        chk("R2 cleared by ack", irq_req_o, 0);
    endtask

    task automatic t_fall();
        do_reset();
        write_cfg(8'h80);
        pin_i[3] = 1'b0;
        step(3);
        chk("R4 req on falling", irq_req_o, 1);
        chk("R4 id", irq_id_o, 3);
        ack_pulse();
        chk("R4 no level after ack", irq_req_o, 0);
        pin_i[3] = 1'b1;
        step(4);
        chk("R4 no req on rising", irq_req_o, 0);
    endtask

    task automatic t_both();
        do_reset();
        write_cfg(8'h03);
        pin_i[0] = 1'b0;
        step(3);
        chk("R5 req on falling", irq_req_o, 1);
        chk("R5 id", irq_id_o, 0);
        ack_pulse();
        chk("R5 cleared", irq_req_o, 0);
        pin_i[0] = 1'b1;
        step(3);
        chk("R5 req on rising", irq_req_o, 1);
        ack_pulse();
        chk("R5 cleared again", irq_req_o, 0);
    endtask

    task automatic t_enable();
        do_reset();
        pin_dir_i[1] = 1'b1;
        pin_i[1] = 1'b0;
        step(4);
        chk("R6 output pin gives no req", irq_req_o, 0);
        pin_dir_i[1] = 1'b0; pin_opt_i[1] = 1'b0;
        step(2);
        chk("R6 plain input gives no req", irq_req_o, 0);
        pin_opt_i[1] = 1'b1;
        step(1);
        chk("R6 enabled line requests", irq_req_o, 1);
        chk("R6 id", irq_id_o, 1);
        pin_i[1] = 1'b1;
        step(3);
        chk("R6 no edge left from disabled time", irq_req_o, 0);
    endtask

    task automatic t_prio();
        do_reset();
        write_cfg(8'hAA);
        pin_i[3] = 1'b0; pin_i[1] = 1'b0;
        step(3);
        chk("R7 winner of 1 and 3", irq_id_o, 1);
        ack_pulse();
        chk("R7 next is 3", irq_id_o, 3);
        chk("R7 still requesting", irq_req_o, 1);
        ack_pulse();
        chk("R7 all served", irq_req_o, 0);
        pin_i[0] = 1'b0; pin_i[2] = 1'b0;
        step(3);
        chk("R7 winner of 0 and 2", irq_id_o, 0);
        ack_pulse();
        chk("R7 next is 2", irq_id_o, 2);
        ack_pulse();
        chk("R7 all served again", irq_req_o, 0);
    endtask

    task automatic t_hold();
        do_reset();
        write_cfg(8'hAA);
        ack_pulse();
        chk("R8 idle ack no effect", irq_req_o, 0);
        pin_i[2] = 1'b0;
        step(3);
        chk("R8 req raised", irq_req_o, 1);
        step(10);
        chk("R8 req held", irq_req_o, 1);
        pin_i[2] = 1'b1;
        step(5);
        chk("R8 held after pin returns", irq_req_o, 1);
        chk("R8 id", irq_id_o, 2);
        ack_pulse();
        chk("R8 cleared by ack", irq_req_o, 0);
    endtask

    task automatic t_cfg();
        do_reset();
        write_cfg(8'hAA);
        pin_i[2] = 1'b0; pin_i[3] = 1'b0;
        step(3);
        chk("R9 line 2 wins first", irq_id_o, 2);
        write_cfg(8'hBA);
        chk("R9 other line kept", irq_req_o, 1);
        chk("R9 line 2 cleared", irq_id_o, 3);
        write_cfg(8'hBA);
        chk("R9 same value keeps req", irq_req_o, 1);
        chk("R9 same value keeps id", irq_id_o, 3);
        ack_pulse();
        chk("R9 line 3 acked", irq_req_o, 0);
    endtask

    initial begin : wdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog: actual %0d cycles expected fewer", WD_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_level();
        t_rise();
        t_fall();
        t_both();
        t_enable();
        t_prio();
        t_hold();
        t_cfg();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule